// File: doc/BRIEF.md
# Configurable Logic-Array Macrocell

This block is the storage and output stage that sits behind one OR-term of a programmable logic array. The sum arriving from the array can be stored in a D flip-flop, accumulated in a toggle flip-flop, or passed straight through with no register. Static configuration bits select the clock that drives the register. The clock is either one of the global clocks, each taken on its rising or falling edge, or one of two shared control terms. The configuration also selects whether two further control terms may force the register to 1 or to 0 at any time.

On the output side, the macrocell chooses its pad enable from four shared control terms, or from a constant on or a constant off. A global active-low tri-state input, when armed, overrides that choice and disables the pad. Two values return to the array. The first is the macrocell value, taken before the pad buffer. The second is the pin value, which carries the macrocell value while the pad is driven and the external pad input while it is not. The pad's electrical behaviour is modelled only as the pair of drive value and enable.

Top module: `mcell_reg`

## Requirements
- R1: While `por_n` is 0 the register is held at 0, so in D or T mode `fb_mc` reads 0 even when clock edges arrive; after `por_n` rises the register keeps 0 until an edge or a preset.
- R2: With `cfg_mode` = 1 (D), each active edge of the selected clock loads `sum_in` into the register. Between edges the register holds its value whatever `sum_in` does.
- R3: With `cfg_mode` = 2 (T), an active edge inverts the register when `sum_in` is 1 and leaves it unchanged when `sum_in` is 0.
- R4: With `cfg_mode` = 0 or 3 (combinational), `fb_mc` and `pad_out` equal `sum_in` in the same cycle, independent of any clock.
- R5: The clock source is chosen by `cfg_clk_sel`: values 0 to 3 pick `gclk[0]` to `gclk[3]`, value 4 picks `ct[2]`, value 5 picks `ct[3]`, and values 6 and 7 give no clock. Edges on sources that are not selected have no effect on the register.
- R6: When `cfg_clk_fall` is 1, a selected global clock acts on its falling edge instead of its rising edge. A control-term clock always acts on its rising edge, whatever the value of this bit.
- R7: When `cfg_prst_en` is 1, `ct[0]` = 1 forces the register to 1 and `ct[1]` = 1 forces it to 0, asynchronously and ahead of any clock. When both are 1 the register is 0. If `ct[1]` drops while `ct[0]` stays high, the register becomes 1.
- R8: When `cfg_prst_en` is 0, `ct[0]` and `ct[1]` have no effect on the register.
- R9: The local pad enable is chosen by `cfg_oe_sel`: values 0 to 3 pick `ct[2]` to `ct[5]`, value 4 is always on, and values 5 to 7 are always off.
- R10: When `cfg_gts_en` is 1 and `gts_n` is 0, `pad_oe` is 0 whatever the local enable is. When `cfg_gts_en` is 0, `gts_n` has no effect.
- R11: `pad_out` always equals `fb_mc`. `fb_pin` equals `pad_out` while `pad_oe` is 1 and equals `pad_in` while `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low |
| gclk | input | NUM_GCLK | Global clocks |
| ct | input | 6 | Shared control terms: preset, reset, clocks and enables |
| sum_in | input | 1 | OR-term sum from the logic array |
| gts_n | input | 1 | Global tri-state, active low |
| pad_in | input | 1 | Value seen at the pad from outside |
| cfg_mode | input | 2 | 0/3 combinational, 1 D flip-flop, 2 T flip-flop |
| cfg_clk_sel | input | CSW | Clock source select |
| cfg_clk_fall | input | 1 | Act on the falling edge of a global clock |
| cfg_prst_en | input | 1 | Enable control-term preset and reset |
| cfg_oe_sel | input | 3 | Pad enable source select |
| cfg_gts_en | input | 1 | Arm the global tri-state |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad drive enable |
| fb_mc | output | 1 | Macrocell feedback, taken before the buffer |
| fb_pin | output | 1 | Pin feedback, taken after the buffer |

## Verification
The hardest case to reach is an edge on the register's clock that is produced by reconfiguration rather than by a clock. Changing `cfg_clk_sel` or `cfg_clk_fall` while the sources sit at different levels can move the effective clock from 0 to 1. A second hard case is a preset that is still asserted at the moment a reset or a power-on reset is released. The stimulus steps through source switches, polarity flips and overlapping control-term pulses one input change at a time. The reference model works out every effective clock transition from the inputs alone, so edges caused by reconfiguration are predicted, not avoided.

// File: rtl/mcell_reg.sv
module mcell_reg #(
  parameter int NUM_GCLK = 4,
  localparam int NSRC = NUM_GCLK + 2,
  localparam int CSW = $clog2(NSRC)
) (
  input  logic                por_n,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [5:0]          ct,
  input  logic                sum_in,
  input  logic                gts_n,
  input  logic                pad_in,
  input  logic [1:0]          cfg_mode,
  input  logic [CSW-1:0]      cfg_clk_sel,
  input  logic                cfg_clk_fall,
  input  logic                cfg_prst_en,
  input  logic [2:0]          cfg_oe_sel,
  input  logic                cfg_gts_en,
  output logic                pad_out,
  output logic                pad_oe,
  output logic                fb_mc,
  output logic                fb_pin
);
  localparam logic [1:0] MODE_D = 2'd1;
  localparam logic [1:0] MODE_T = 2'd2;

  logic [NSRC-1:0]     src;
  logic [2**CSW-1:0]   src_pad;
  logic                clk_eff;
  logic [7:0]          oe_src;
  logic                oe_loc;
  logic                rst_int;
  logic                set_int;
  logic                q;
  logic                use_reg;
  logic                mc_out;

  assign src = {ct[3], ct[2], gclk ^ {NUM_GCLK{cfg_clk_fall}}};

  always_comb begin
    src_pad = '0;
    src_pad[NSRC-1:0] = src;
  end

  assign clk_eff = src_pad[cfg_clk_sel];

  assign rst_int = ~por_n | (cfg_prst_en & ct[1]);
  assign set_int = por_n & cfg_prst_en & ct[0] & ~ct[1];

  always_ff @(posedge clk_eff or posedge rst_int or posedge set_int) begin
    if (rst_int)              q <= 1'b0;
    else if (set_int)         q <= 1'b1;
    else if (cfg_mode == MODE_T) q <= q ^ sum_in;
    else                      q <= sum_in;
  end

  assign use_reg = (cfg_mode == MODE_D) || (cfg_mode == MODE_T);
  assign mc_out  = use_reg ? q : sum_in;

  assign oe_src = {3'b000, 1'b1, ct[5:2]};
  assign oe_loc = oe_src[cfg_oe_sel];
  assign pad_oe = oe_loc & ~(cfg_gts_en & ~gts_n);

  assign pad_out = mc_out;
  assign fb_mc   = mc_out;
  assign fb_pin  = pad_oe ? mc_out : pad_in;
endmodule

// File: rtl/mcell_reg_chk.sv
module mcell_reg_chk (
  input logic       por_n,
  input logic       gclk0,
  input logic [1:0] ct_pr,
  input logic       sum_in,
  input logic       gts_n,
  input logic       pad_in,
  input logic [1:0] cfg_mode,
  input logic       cfg_prst_en,
  input logic       cfg_gts_en,
  input logic       pad_oe,
  input logic       fb_mc,
  input logic       fb_pin
);
  logic regmode;
  assign regmode = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);

  AST_GTS_FORCES_OFF: assert property (@(posedge gclk0) disable iff (!por_n)
    (cfg_gts_en && !gts_n) |-> !pad_oe); // R10

  AST_COMB_PASS: assert property (@(posedge gclk0) disable iff (!por_n)
    !regmode |-> (fb_mc == sum_in)); // R4

  AST_RESET_WINS: assert property (@(posedge gclk0) disable iff (!por_n)
    (regmode && cfg_prst_en && ct_pr[1]) |-> !fb_mc); // R7

  AST_PRESET_HOLDS: assert property (@(posedge gclk0) disable iff (!por_n)
    (regmode && cfg_prst_en && ct_pr[0] && !ct_pr[1]) |-> fb_mc); // R7

  AST_PIN_FEEDBACK: assert property (@(posedge gclk0) disable iff (!por_n)
    !pad_oe |-> (fb_pin == pad_in)); // R11
endmodule

bind mcell_reg mcell_reg_chk u_chk (
  .por_n(por_n), .gclk0(gclk[0]), .ct_pr(ct[1:0]), .sum_in(sum_in),
  .gts_n(gts_n), .pad_in(pad_in), .cfg_mode(cfg_mode),
  .cfg_prst_en(cfg_prst_en), .cfg_gts_en(cfg_gts_en),
  .pad_oe(pad_oe), .fb_mc(fb_mc), .fb_pin(fb_pin)
);

// File: tb/mcell_reg_tb.sv
module mcell_reg_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       por_n = 1'b0;
  logic [3:0] gclk = '0;
  logic [5:0] ct = '0;
  logic       sum_in = 1'b0, gts_n = 1'b1, pad_in = 1'b0;
  logic [1:0] cfg_mode = 2'd1;
  logic [2:0] cfg_clk_sel = 3'd0;
  logic       cfg_clk_fall = 1'b0, cfg_prst_en = 1'b0, cfg_gts_en = 1'b0;
  logic [2:0] cfg_oe_sel = 3'd4;
  logic       pad_out, pad_oe, fb_mc, fb_pin;

  mcell_reg u_dut (
    .por_n(por_n), .gclk(gclk), .ct(ct), .sum_in(sum_in), .gts_n(gts_n),
    .pad_in(pad_in), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
    .cfg_clk_fall(cfg_clk_fall), .cfg_prst_en(cfg_prst_en),
    .cfg_oe_sel(cfg_oe_sel), .cfg_gts_en(cfg_gts_en),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_mc(fb_mc), .fb_pin(fb_pin)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  bit mq = 0;
  bit prev_eff = 0;

  function automatic bit model_clk();
    case (cfg_clk_sel)
      3'd0, 3'd1, 3'd2, 3'd3: return gclk[cfg_clk_sel[1:0]] ^ cfg_clk_fall;
      3'd4: return ct[2];
      3'd5: return ct[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit model_oe();
    bit loc;
    if (cfg_oe_sel <= 3'd3) loc = ct[2 + int'(cfg_oe_sel)];
    else loc = (cfg_oe_sel == 3'd4);
    return loc && !(cfg_gts_en && !gts_n);
  endfunction

  task automatic step(input string tag);
    bit eff, e_mc, e_oe, e_pin, regm;
    eff = model_clk();
    if (!prev_eff && eff) mq = (cfg_mode == 2'd2) ? (mq ^ sum_in) : sum_in;
    if (!por_n || (cfg_prst_en && ct[1])) mq = 1'b0;
    else if (cfg_prst_en && ct[0]) mq = 1'b1;
    prev_eff = eff;
    regm = (cfg_mode == 2'd1) || (cfg_mode == 2'd2);
    e_mc = regm ? mq : sum_in;
    e_oe = model_oe();
    e_pin = e_oe ? e_mc : pad_in;
    @(posedge clk);
    checks++;
    if (fb_mc !== e_mc || pad_out !== e_mc || pad_oe !== e_oe || fb_pin !== e_pin) begin
      failures++;
      $display("FAIL %s: mc=%b out=%b oe=%b pin=%b expected mc=%b out=%b oe=%b pin=%b",
               tag, fb_mc, pad_out, pad_oe, fb_pin, e_mc, e_mc, e_oe, e_pin);
    end
    @(negedge clk);
  endtask

  task automatic gpulse(input int i, input string tag);
    gclk[i] = 1'b1; step(tag);
    gclk[i] = 1'b0; step(tag);
  endtask

  task automatic cpulse(input int i, input string tag);
    ct[i] = 1'b1; step(tag);
    ct[i] = 1'b0; step(tag);
  endtask

  initial begin
    @(negedge clk);
    step("R1 reset state");
    sum_in = 1'b1;
    gpulse(0, "R1 edge during reset");
    por_n = 1'b1; step("R1 after release");

    gpulse(0, "R2 load 1");
    sum_in = 1'b0; step("R2 hold between edges");
    gpulse(0, "R2 load 0");
    sum_in = 1'b1; step("R2 hold");

    cfg_clk_sel = 3'd1; step("R5 select gclk1");
    gpulse(0, "R5 unselected gclk0 ignored");
    gpulse(1, "R5 gclk1 loads");
    sum_in = 1'b0;
    gpulse(3, "R5 gclk3 ignored");
    cfg_clk_sel = 3'd4; step("R5 select ct2");
    cpulse(2, "R5 ct2 clock loads 0");
    sum_in = 1'b1;
    cpulse(3, "R5 ct3 ignored while ct2 selected");
    cfg_clk_sel = 3'd5; step("R5 select ct3");
    cpulse(3, "R5 ct3 clock loads 1");
    cfg_clk_sel = 3'd6; sum_in = 1'b0; step("R5 no clock");
    for (int i = 0; i < 4; i++) gpulse(i, "R5 no-clock select ignores all");
    cpulse(2, "R5 no-clock select ignores ct2");

    cfg_clk_sel = 3'd2; step("R6 select gclk2");
    cfg_clk_fall = 1'b1; step("R6 polarity change");
    sum_in = 1'b1;
    gclk[2] = 1'b1; step("R6 rising edge ignored");
    gclk[2] = 1'b0; step("R6 falling edge loads");
    sum_in = 1'b0;
    gpulse(2, "R6 falling edge loads 0");
    cfg_clk_sel = 3'd4; step("R6 ct clock");
    sum_in = 1'b1;
    ct[2] = 1'b1; step("R6 ct2 rising loads despite fall bit");
    ct[2] = 1'b0; step("R6 ct2 falling ignored");
    cfg_clk_fall = 1'b0; cfg_clk_sel = 3'd0; step("R6 back to gclk0");

    cfg_mode = 2'd2; sum_in = 1'b1; step("R3 enter T");
    for (int i = 0; i < 3; i++) gpulse(0, "R3 toggle");
    sum_in = 1'b0;
    gpulse(0, "R3 hold");
    gpulse(0, "R3 hold again");

    cfg_mode = 2'd0; step("R4 comb");
    for (int i = 0; i < 4; i++) begin sum_in = ~sum_in; step("R4 pass through"); end
    cfg_mode = 2'd3; sum_in = 1'b1; step("R4 mode 3 comb");
    gpulse(0, "R4 clock no effect");
    sum_in = 1'b0; step("R4 mode 3 pass 0");

    cfg_mode = 2'd1; step("R7 back to D");
    cfg_prst_en = 1'b1;
    ct[0] = 1'b1; step("R7 preset");
    ct[0] = 1'b0; step("R7 preset released holds");
    ct[1] = 1'b1; step("R7 reset");
    ct[0] = 1'b1; step("R7 both asserted reset wins");
    sum_in = 1'b1;
    gpulse(0, "R7 clock blocked by reset");
    ct[1] = 1'b0; step("R7 reset dropped preset held");
    ct[0] = 1'b0; step("R7 all released");
    sum_in = 1'b0;
    gpulse(0, "R7 clock after release");

    cfg_prst_en = 1'b0;
    ct[0] = 1'b1; step("R8 preset disabled");
    ct[0] = 1'b0; sum_in = 1'b1;
    gpulse(0, "R8 load 1");
    ct[1] = 1'b1; step("R8 reset disabled");
    ct[0] = 1'b1; step("R8 both disabled");
    ct[1:0] = 2'b00; step("R8 released");

    for (int s = 0; s < 8; s++) begin
      cfg_oe_sel = 3'(s);
      for (int p = 0; p < 16; p += 5) begin
        ct[5:2] = 4'(p); step("R9 enable select");
      end
    end
    ct[5:2] = 4'b0000;

    cfg_oe_sel = 3'd4; cfg_gts_en = 1'b1; gts_n = 1'b0; step("R10 forced off");
    gts_n = 1'b1; step("R10 released");
    cfg_gts_en = 1'b0; gts_n = 1'b0; step("R10 not armed");
    gts_n = 1'b1;

    pad_in = 1'b0; cfg_oe_sel = 3'd5; step("R11 pin from pad");
    pad_in = 1'b1; step("R11 pin from pad 1");
    sum_in = 1'b0;
    gpulse(0, "R11 mc 0 pad 1");
    cfg_oe_sel = 3'd4; step("R11 pin from macrocell");
    cfg_gts_en = 1'b1; gts_n = 1'b0; step("R11 pin from pad under gts");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule